// File: doc/BRIEF.md
# Cache-Line Boundary Write Disconnector

This block acts as the target of Memory Write and Invalidate bursts on a bridge's initiating bus. It puts every accepted DWORD into a posted-buffer write port. When the command is a Memory Write and Invalidate and the cache line size register holds a usable value, it stops the burst at the next aligned cache-line boundary. It does this with a disconnect-with-data: STOP# is asserted together with TRDY# on the last DWORD of the line, so that DWORD is still accepted.

The line size is given in DWORDs. It is usable when it is a power of two no larger than the `LINE_MAX` parameter. Any other value turns the burst into an ordinary posted memory write that the initiator ends on its own. The command and the line size are captured in the address phase, and they hold for the whole burst. Storage of the data and forwarding to the other bus are outside this block.

The control is a three-state machine:

- `S_IDLE` waits for FRAME# low. That cycle is the address phase, and the machine goes to `S_XFER`.
- In `S_XFER`, DEVSEL# and TRDY# are low. A data phase completes when IRDY# is also low.
  - A completed phase with FRAME# high goes back to `S_IDLE`.
  - A completed phase with STOP# low and FRAME# still low goes to `S_DISC`.
- `S_DISC` holds STOP# low and TRDY# high until FRAME# rises, then returns to `S_IDLE`.

Top module: `mwic_line_cutter`

## Requirements
- R1: After reset, DEVSEL#, TRDY# and STOP# are high and the write enable is low until an address phase arrives.
- R2: In the cycle after an address phase (FRAME# sampled low while idle), DEVSEL# and TRDY# are low.
- R3: Each completed data phase (IRDY# and TRDY# both low) raises the write enable for that cycle. It presents the data and a DWORD address equal to the start address plus the number of DWORDs already accepted.
- R4: A line size is valid only if it is a nonzero power of two not above LINE_MAX (64 by default). Values such as 0, 6 or 128 are invalid.
- R5: For a Memory Write and Invalidate with a valid line size L, STOP# goes low together with TRDY# exactly on the DWORD whose address modulo L equals L-1. That DWORD is written.
- R6: After a disconnect with FRAME# still low, STOP# stays low and TRDY# stays high until FRAME# rises. The block is then idle again.
- R7: With an invalid line size, or with a command that is not Memory Write and Invalidate, STOP# stays high and the burst runs for the full length the initiator requests.
- R8: The line size is captured in the address phase. Changing the register during a burst does not move the disconnect point.
- R9: A burst that starts on the last DWORD of a line is disconnected after that single DWORD.
- R10: A cycle with IRDY# high in the middle of a burst writes nothing and does not advance the address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low reset |
| frame_n | input | 1 | FRAME#, driven by the initiator |
| irdy_n | input | 1 | IRDY#, driven by the initiator |
| cmd_mwi | input | 1 | High during the address phase when the command is Memory Write and Invalidate |
| start_addr | input | ADDR_W | DWORD address of the burst, valid in the address phase |
| ad_data | input | DATA_W | Write data of the current data phase |
| line_size | input | CLS_W | Cache line size register, in DWORDs |
| devsel_n | output | 1 | DEVSEL# |
| trdy_n | output | 1 | TRDY# |
| stop_n | output | 1 | STOP# |
| wr_en | output | 1 | Posted-buffer write strobe |
| wr_addr | output | ADDR_W | DWORD address of the written word |
| wr_data | output | DATA_W | Written word |
| wr_last | output | 1 | Marks the final DWORD of the burst |

## Verification
The hardest case to reach from the ports is the one where the initiator's own last DWORD lands on a line boundary. In that data phase, FRAME# high and the forced STOP# both arrive together, and the machine must return to idle rather than wait in `S_DISC`. The stimulus table includes a burst whose requested length ends exactly at the line's last DWORD to create this case. Directed bursts cover two more cases: initiator wait states in the middle of a burst, and a line-size change after the first DWORD. Both check that the disconnect point and the address sequence do not move.

// File: rtl/mwic_pkg.sv
package mwic_pkg;

    typedef enum logic [1:0] {
        S_IDLE = 2'd0,
        S_XFER = 2'd1,
        S_DISC = 2'd2
    } mwic_state_e;

    // True for a nonzero value with exactly one bit set.
    function automatic logic is_pow2(input logic [15:0] v);
        return (v != 16'd0) && ((v & (v - 16'd1)) == 16'd0);
    endfunction

endpackage

// File: rtl/mwic_line_check.sv
module mwic_line_check #(
    parameter int CLS_W    = 8,
    parameter int LINE_MAX = 64
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CLS_W-1:0] line_size,
    output logic             size_ok,
    output logic [CLS_W-1:0] line_mask
);
    import mwic_pkg::*;

    localparam logic [CLS_W:0] LMAX = LINE_MAX[CLS_W:0];

    logic [15:0] size_wide;

    always_comb begin
        size_wide = 16'(line_size);
        size_ok   = is_pow2(size_wide) && ({1'b0, line_size} <= LMAX);
        line_mask = line_size - 1'b1;
    end

    AST_VALID_IS_POW2: assert property (@(posedge clk) disable iff (!rst_n)
        size_ok |-> ($countones(line_size) == 1)) else $error("size check"); // R4

endmodule

// File: rtl/mwic_addr_track.sv
module mwic_addr_track #(
    parameter int ADDR_W = 30,
    parameter int CLS_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [ADDR_W-1:0] load_addr,
    input  logic [CLS_W-1:0]  load_mask,
    input  logic              adv,
    output logic [ADDR_W-1:0] cur_addr,
    output logic              at_line_end
);
    localparam int PAD_W = ADDR_W - CLS_W;

    logic [CLS_W-1:0]  mask_q;
    logic [ADDR_W-1:0] mask_ext;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_addr <= '0;
            mask_q   <= '0;
        end else if (load) begin
            cur_addr <= load_addr;
            mask_q   <= load_mask;
        end else if (adv) begin
            cur_addr <= cur_addr + 1'b1;
        end
    end

    always_comb begin
        mask_ext    = {{PAD_W{1'b0}}, mask_q};
        at_line_end = ((cur_addr & mask_ext) == mask_ext);
    end

    AST_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !adv) |=> $stable(cur_addr)) else $error("addr moved"); // R10
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !load |=> $stable(mask_q)) else $error("mask moved"); // R8

endmodule

// File: rtl/mwic_line_cutter.sv
module mwic_line_cutter #(
    parameter int ADDR_W   = 30,
    parameter int DATA_W   = 32,
    parameter int CLS_W    = 8,
    parameter int LINE_MAX = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_n,
    input  logic              irdy_n,
    input  logic              cmd_mwi,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic [DATA_W-1:0] ad_data,
    input  logic [CLS_W-1:0]  line_size,
    output logic              devsel_n,
    output logic              trdy_n,
    output logic              stop_n,
    output logic              wr_en,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [DATA_W-1:0] wr_data,
    output logic              wr_last
);
    import mwic_pkg::*;

    mwic_state_e      state_q, state_d;
    logic             cut_q;
    logic             size_ok;
    logic [CLS_W-1:0] line_mask;
    logic             addr_phase;
    logic             xfer;
    logic             at_line_end;
    logic [ADDR_W-1:0] cur_addr;

    mwic_line_check #(.CLS_W(CLS_W), .LINE_MAX(LINE_MAX)) u_check (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_size (line_size),
        .size_ok   (size_ok),
        .line_mask (line_mask)
    );

    mwic_addr_track #(.ADDR_W(ADDR_W), .CLS_W(CLS_W)) u_track (
        .clk         (clk),
        .rst_n       (rst_n),
        .load        (addr_phase),
        .load_addr   (start_addr),
        .load_mask   (line_mask),
        .adv         (xfer),
        .cur_addr    (cur_addr),
        .at_line_end (at_line_end)
    );

    assign addr_phase = (state_q == S_IDLE) && !frame_n;
    assign xfer       = (state_q == S_XFER) && !irdy_n;

    // State register and captured cut decision
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= S_IDLE;
            cut_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (addr_phase) cut_q <= cmd_mwi && size_ok;
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (!frame_n) state_d = S_XFER;
            S_XFER: begin
                if (xfer && frame_n)                 state_d = S_IDLE;
                else if (xfer && cut_q && at_line_end) state_d = S_DISC;
            end
            S_DISC: if (frame_n) state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        devsel_n = 1'b1;
        trdy_n   = 1'b1;
        stop_n   = 1'b1;
        unique case (state_q)
            S_IDLE: ;
            S_XFER: begin
                devsel_n = 1'b0;
                trdy_n   = 1'b0;
                stop_n   = !(cut_q && at_line_end);
            end
            S_DISC: begin
                devsel_n = 1'b0;
                stop_n   = 1'b0;
            end
            default: ;
        endcase
        wr_en   = xfer;
        wr_addr = cur_addr;
        wr_data = ad_data;
        wr_last = xfer && (frame_n || !stop_n);
    end

    AST_WR_NEEDS_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |-> (!trdy_n && !devsel_n && !irdy_n)) else $error("write w/o trdy"); // R3
    AST_STOP_WITH_TRDY: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !devsel_n && $past(devsel_n)) |-> !trdy_n) else $error("stop w/o data"); // R5
    AST_DISC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!stop_n && !trdy_n && !irdy_n && !frame_n) |=> (!stop_n && trdy_n && !devsel_n)) else $error("disc hold"); // R6
    AST_NO_CUT_PLAIN: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == S_XFER) && !cut_q) |-> stop_n) else $error("cut w/o mwi"); // R7
    AST_CLAIM_AFTER_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        addr_phase |=> (!devsel_n && !trdy_n)) else $error("no claim"); // R2

endmodule

// File: tb/mwic_line_cutter_tb.sv
module mwic_line_cutter_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_n = 1'b1;
    logic        irdy_n = 1'b1;
    logic        cmd_mwi = 1'b0;
    logic [29:0] start_addr = '0;
    logic [31:0] ad_data = '0;
    logic [7:0]  line_size = 8'd8;
    logic        devsel_n, trdy_n, stop_n, wr_en, wr_last;
    logic [29:0] wr_addr;
    logic [31:0] wr_data;

    int n_run = 0;
    int n_fail = 0;

    always #2.5 clk = ~clk;

    mwic_line_cutter u_dut (
        .clk(clk), .rst_n(rst_n), .frame_n(frame_n), .irdy_n(irdy_n),
        .cmd_mwi(cmd_mwi), .start_addr(start_addr), .ad_data(ad_data),
        .line_size(line_size), .devsel_n(devsel_n), .trdy_n(trdy_n),
        .stop_n(stop_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .wr_last(wr_last)
    );

    // {mwi, line size, start addr, requested length}
    localparam logic [32:0] VEC [12] = '{
        {1'b1, 8'd8,   16'd0,  8'd20},
        {1'b1, 8'd8,   16'd5,  8'd20},
        {1'b1, 8'd8,   16'd7,  8'd5},
        {1'b1, 8'd4,   16'd2,  8'd2},
        {1'b1, 8'd16,  16'd0,  8'd4},
        {1'b1, 8'd6,   16'd0,  8'd12},
        {1'b1, 8'd0,   16'd3,  8'd5},
        {1'b0, 8'd8,   16'd0,  8'd12},
        {1'b1, 8'd1,   16'd9,  8'd3},
        {1'b1, 8'd128, 16'd0,  8'd10},
        {1'b1, 8'd32,  16'd30, 8'd6},
        {1'b1, 8'd64,  16'd60, 8'd10}
    };

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    function automatic bit size_valid(input int cls);
        return (cls > 0) && (cls <= 64) && ((cls & (cls - 1)) == 0);
    endfunction

    function automatic int exp_count(input bit mwi, input int cls, input int a, input int len);
        int r;
        if (mwi && size_valid(cls)) begin
            r = cls - (a % cls);
            return (r < len) ? r : len;
        end
        return len;
    endfunction

    task automatic run_burst(input bit mwi, input int cls, input int a, input int len,
                             input bit waits, input bit cls_alt);
        int got = 0;
        int cyc = 0;
        bit done = 0;
        bit stopped = 0;
        bit cut = mwi && size_valid(cls);
        int expn = exp_count(mwi, cls, a, len);
        @(negedge clk);
        frame_n = 1'b0; irdy_n = 1'b1; cmd_mwi = mwi;
        line_size = 8'(cls); start_addr = 30'(a);
        @(negedge clk);
        #1;
        check(!devsel_n && !trdy_n, "R2", "claim after address", int'(devsel_n), 0);
        while (!done && cyc < 300) begin
            cyc++;
            irdy_n  = (waits && (cyc % 3 == 0)) ? 1'b1 : 1'b0;
            frame_n = (!irdy_n && got == len - 1) ? 1'b1 : 1'b0;
            ad_data = 32'hA500_0000 + 32'(got);
            if (cls_alt && got == 1) line_size = 8'd64;
            #1;
            if (!irdy_n && !trdy_n) begin
                check(wr_en && wr_addr == 30'(a + got) && wr_data == ad_data,
                      "R3", "write port", int'(wr_addr), a + got);
                check(stop_n == !(cut && ((a + got) % cls == cls - 1)), "R5",
                      "stop at line end", int'(stop_n), int'(!(cut && ((a + got) % cls == cls - 1))));
                got++;
                if (!stop_n || frame_n) begin
                    done = 1;
                    stopped = !frame_n;
                end
            end else begin
                check(!wr_en, "R10", "no write on wait", int'(wr_en), 0);
            end
            @(negedge clk);
        end
        if (stopped) begin
            frame_n = 1'b1; irdy_n = 1'b1;
            #1;
            check(!stop_n && trdy_n && !devsel_n, "R6", "stop held", int'(stop_n), 0);
            @(negedge clk);
        end else begin
            frame_n = 1'b1; irdy_n = 1'b1;
        end
        #1;
        check(stop_n && devsel_n && trdy_n, "R6", "idle after burst", int'(devsel_n), 1);
        check(got == expn, cut ? "R5" : "R7", "dwords accepted", got, expn);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check(devsel_n && trdy_n && stop_n && !wr_en, "R1", "outputs in reset", int'(devsel_n), 1);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        check(devsel_n && trdy_n && stop_n && !wr_en, "R1", "idle after reset", int'(wr_en), 0);

        // Table walk: R4, R5, R7, R9 cases
        foreach (VEC[i]) begin
            run_burst(VEC[i][32], int'(VEC[i][31:24]), int'(VEC[i][23:8]),
                      int'(VEC[i][7:0]), 1'b0, 1'b0);
        end

        // R10: wait states in the middle of a line
        run_burst(1'b1, 8, 4, 20, 1'b1, 1'b0);
        // R8: register changes after the first DWORD
        run_burst(1'b1, 4, 0, 10, 1'b0, 1'b1);
        // R9: start on the last DWORD of a 16-DWORD line, with wait states
        run_burst(1'b1, 16, 31, 8, 1'b1, 1'b0);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule